// File: doc/BRIEF.md
# Multichannel ADC Sequencer Register Block

This block sits between a simple synchronous register bus and a single-shot analog-to-digital converter core. Software reaches it through address, write data, write enable, read enable and read data. It uses the block to enable the converter, pick one of 32 input channels and one of four input ranges, choose the conversion width and a repeat count, and start a run. A run issues one request to the converter core for each conversion. When the core reports done, the block latches the 12-bit result. After the final conversion of the run it sets a sticky raw completion flag.

The raw flag is cleared by writing one to a dedicated clear register. It is also masked by an interrupt-enable bit to give a status bit, and that status bit drives a level interrupt. Software follows this order: enable, clear pending, write channel and range, write mode and count, set the run bit, then poll the raw flag or wait for the interrupt. Channel, range and mode are captured when the run starts. Clearing the enable bit aborts the run.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `conv_req_o` is 0.
- R2: Register map and field positions:
  - control at 0x00: enable bit 0, run bit 1, 12-bit mode bit 2, repeat count bits 7:4;
  - channel setup at 0x04: channel bits 4:0, range bits 10:9, all other bits read 0;
  - data at 0x4C, interrupt enable at 0x50 (bit 0), clear at 0x54, masked status at 0x58 (bit 0), raw flag at 0x5C (bit 0).
  - Writable fields read back as written, and the clear register reads 0.
- R3: A write to control is a run request when write-data bits 0 and 1 are both 1. When the enable bit is already set and no run is outstanding, such a write makes `conv_req_o` high for exactly one cycle, in the cycle after the write. During that cycle `conv_chan_o`, `conv_scale_o` and `conv_mode12_o` carry the programmed values. The run bit reads 1 until the run ends.
- R4: On the done of the final conversion, the data register takes `conv_data_i` in bits 11:0 with its upper bits 0, and the run bit reads 0 from the next cycle on.
- R5: The raw flag sets on the done of the final conversion of a run. It holds until a write to 0x54 with bit 0 set. Writing 0 there has no effect. A set and a clear in the same cycle leave the flag set.
- R6: Status bit 0 is the raw flag ANDed with enable bit 0, and `irq_o` follows the status bit.
- R7: A repeat count N gives N+1 conversions. Each request follows the previous done. The raw flag stays 0 until the last done, and the data register holds the last result.
- R8: Writes to the channel setup register during a run do not change `conv_chan_o` or `conv_scale_o` until the next run starts.
- R9: A control write with bit 0 clear aborts a run:
  - the run bit drops and no further request is made;
  - a done that arrives later leaves the data register and the raw flag unchanged.
- R10: A run request is ignored when the enable bit is not already set before the write, including a write that sets enable and run together. A run request is also ignored while a run is outstanding, and it does not restart the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe, gates read data |
| rdata_o | output | 32 | Read data, combinational from address |
| conv_req_o | output | 1 | One-cycle conversion request to the core |
| conv_chan_o | output | 5 | Channel captured for the active run |
| conv_scale_o | output | 2 | Input range captured for the active run |
| conv_mode12_o | output | 1 | 12-bit mode captured for the active run |
| conv_done_i | input | 1 | Core reports a finished conversion |
| conv_data_i | input | 12 | Core conversion result |
| irq_o | output | 1 | Level completion interrupt |

## Verification
Two cases are hard to reach from the ports:
- A raw-flag clear that lands on the same cycle as a final done. The bench drives the clear write and the core's done strobe in one cycle from a hand-timed sequence.
- An abort, or a repeated run request, that falls inside the wait for the core. The bench holds `conv_done_i` back, writes the control register during the wait, and only then lets the core answer.

The run bit, the data register and the raw flag are then read to confirm that the late done was discarded or that only the original count was served.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CHCFG = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DATA  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_ICLR  = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_ISTS  = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_IRAW  = 8'h5C;

  localparam int unsigned EN_B      = 0;
  localparam int unsigned RUN_B     = 1;
  localparam int unsigned M12_B     = 2;
  localparam int unsigned CNT_LSB   = 4;
  localparam int unsigned CH_LSB    = 0;
  localparam int unsigned SCALE_LSB = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_state_e;
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W  = 5,
  parameter int unsigned SCALE_W = 2,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic               busy_i,
  output logic               en_o,
  output logic               mode12_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CHAN_W-1:0]  chan_o,
  output logic [SCALE_W-1:0] scale_o,
  output logic               start_o,
  output logic               abort_o
);
  logic wr_ctrl, wr_chcfg;

  assign wr_ctrl  = we_i && (addr_i == OFF_CTRL);
  assign wr_chcfg = we_i && (addr_i == OFF_CHCFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      mode12_o <= 1'b0;
      cnt_o    <= '0;
      chan_o   <= '0;
      scale_o  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_o     <= wdata_i[EN_B];
        mode12_o <= wdata_i[M12_B];
        cnt_o    <= wdata_i[CNT_LSB +: CNT_W];
      end
      if (wr_chcfg) begin
        chan_o  <= wdata_i[CH_LSB +: CHAN_W];
        scale_o <= wdata_i[SCALE_LSB +: SCALE_W];
      end
    end
  end

  // run honoured only when enable was already set and nothing is outstanding
  assign start_o = wr_ctrl && wdata_i[RUN_B] && wdata_i[EN_B] && en_o && !busy_i;
  assign abort_o = wr_ctrl && !wdata_i[EN_B];
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned CHAN_W  = 5,
  parameter int unsigned SCALE_W = 2,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               mode12_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               done_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               req_o,
  output logic               busy_o,
  output logic [CHAN_W-1:0]  chan_o,
  output logic [SCALE_W-1:0] scale_o,
  output logic               mode12_o,
  output logic               fin_o,
  output logic [DATA_W-1:0]  data_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] left_q;
  logic             take;

  assign take   = (state_q == ST_WAIT) && done_i && !abort_i;
  assign fin_o  = take && (left_q == '0);
  assign req_o  = (state_q == ST_REQ);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      left_q   <= '0;
      chan_o   <= '0;
      scale_o  <= '0;
      mode12_o <= 1'b0;
      data_o   <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          chan_o   <= chan_i;
          scale_o  <= scale_i;
          mode12_o <= mode12_i;
          left_q   <= cnt_i;
          state_q  <= ST_REQ;
        end
        ST_REQ:  state_q <= ST_WAIT;
        ST_WAIT: if (take) begin
          data_o <= data_i;
          if (left_q == '0) begin
            state_q <= ST_IDLE;
          end else begin
            left_q  <= left_q - CNT_W'(1);
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbit0_i,
  input  logic              set_i,
  output logic              raw_o,
  output logic              ie_o,
  output logic              sts_o
);
  logic clr;

  assign clr = we_i && (addr_i == OFF_ICLR) && wbit0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o <= 1'b0;
      ie_o  <= 1'b0;
    end else begin
      if (set_i)    raw_o <= 1'b1;  // new event beats a clear
      else if (clr) raw_o <= 1'b0;
      if (we_i && (addr_i == OFF_IEN)) ie_o <= wbit0_i;
    end
  end

  assign sts_o = raw_o & ie_o;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned CHAN_W  = 5,
  parameter int unsigned SCALE_W = 2,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               conv_req_o,
  output logic [CHAN_W-1:0]  conv_chan_o,
  output logic [SCALE_W-1:0] conv_scale_o,
  output logic               conv_mode12_o,
  input  logic               conv_done_i,
  input  logic [DATA_W-1:0]  conv_data_i,
  output logic               irq_o
);
  logic               en_q, mode12_q, start, abort, busy, fin;
  logic               raw_q, ie_q, sts;
  logic [CNT_W-1:0]   cnt_q;
  logic [CHAN_W-1:0]  chan_q;
  logic [SCALE_W-1:0] scale_q;
  logic [DATA_W-1:0]  data_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  adc_seq_cfg #(.CHAN_W(CHAN_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W)) i_cfg (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .busy_i(busy), .en_o(en_q), .mode12_o(mode12_q), .cnt_o(cnt_q),
    .chan_o(chan_q), .scale_o(scale_q), .start_o(start), .abort_o(abort)
  );

  adc_seq_engine #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W)) i_engine (
    .clk_i, .rst_ni, .start_i(start), .abort_i(abort),
    .chan_i(chan_q), .scale_i(scale_q), .mode12_i(mode12_q), .cnt_i(cnt_q),
    .done_i(conv_done_i), .data_i(conv_data_i),
    .req_o(conv_req_o), .busy_o(busy), .chan_o(conv_chan_o), .scale_o(conv_scale_o),
    .mode12_o(conv_mode12_o), .fin_o(fin), .data_o(data_q)
  );

  adc_seq_irq i_irq (
    .clk_i, .rst_ni, .we_i, .addr_i, .wbit0_i(wdata_i[0]),
    .set_i(fin), .raw_o(raw_q), .ie_o(ie_q), .sts_o(sts)
  );

  assign irq_o = sts;

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (addr_i)
        OFF_CTRL: begin
          rdata_o[EN_B]                 = en_q;
          rdata_o[RUN_B]                = busy;
          rdata_o[M12_B]                = mode12_q;
          rdata_o[CNT_LSB +: CNT_W]     = cnt_q;
        end
        OFF_CHCFG: begin
          rdata_o[CH_LSB +: CHAN_W]     = chan_q;
          rdata_o[SCALE_LSB +: SCALE_W] = scale_q;
        end
        OFF_DATA: rdata_o[DATA_W-1:0] = data_q;
        OFF_IEN:  rdata_o[0] = ie_q;
        OFF_ISTS: rdata_o[0] = sts;
        OFF_IRAW: rdata_o[0] = raw_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W  = 5,
  parameter int unsigned SCALE_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [BUS_W-1:0]   wdata_i,
  input logic               conv_req_o,
  input logic               conv_done_i,
  input logic [CHAN_W-1:0]  conv_chan_o,
  input logic [SCALE_W-1:0] conv_scale_o,
  input logic               irq_o,
  input logic               en_q,
  input logic               busy,
  input logic               raw_q
);
  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> en_q); // R10
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o); // R3
  AST_CHAN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(conv_chan_o) && $stable(conv_scale_o))); // R8
  AST_ABORT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_CTRL && !wdata_i[EN_B]) |=> (!busy && !conv_req_o)); // R9
  AST_RAW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q && !(we_i && addr_i == OFF_ICLR && wdata_i[0])) |=> raw_q); // R5
  AST_RAW_FROM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_q) |-> $past(conv_done_i)); // R7
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raw_q); // R6
endmodule

bind adc_seq_top adc_seq_chk #(.CHAN_W(CHAN_W), .SCALE_W(SCALE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .conv_req_o(conv_req_o), .conv_done_i(conv_done_i), .conv_chan_o(conv_chan_o),
  .conv_scale_o(conv_scale_o), .irq_o(irq_o), .en_q(en_q), .busy(busy), .raw_q(raw_q)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  localparam logic [7:0] A_CTRL = 8'h00, A_CH = 8'h04, A_DATA = 8'h4C, A_IEN = 8'h50,
                         A_CLR = 8'h54, A_STS = 8'h58, A_RAW = 8'h5C;
  // chan(5) scale(2) cnt(4) ie(1) data(12)
  localparam logic [23:0] VEC [4] = '{
    {5'd3,  2'd1, 4'd0, 1'b1, 12'hABC},
    {5'd31, 2'd3, 4'd2, 1'b0, 12'h123},
    {5'd0,  2'd0, 4'd1, 1'b1, 12'hFFF},
    {5'd17, 2'd2, 4'd0, 1'b0, 12'h000}
  };

  logic        clk = 0, rst_ni = 0, we = 0, re = 0, done = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [11:0] cdata = '0;
  logic        req, mode12, irq;
  logic [4:0]  chan;
  logic [1:0]  scale;
  int          checks = 0, errors = 0;
  bit          finished = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  adc_seq_top i_adc_seq_top (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .conv_req_o(req), .conv_chan_o(chan), .conv_scale_o(scale),
    .conv_mode12_o(mode12), .conv_done_i(done), .conv_data_i(cdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; re = 1; #1; d = rdata; re = 0;
  endtask

  task automatic core_done(input logic [11:0] d);
    @(negedge clk); done = 1; cdata = d;
    @(negedge clk); done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    foreach (VEC[i]) begin end
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CH, v);   chk("R1 chcfg", v, 0);
    rd(A_DATA, v); chk("R1 data", v, 0);
    rd(A_RAW, v);  chk("R1 raw", v, 0);
    chk("R1 irq/req", {irq, req}, 0);

    // R2 map and readback
    wr(A_CH, 32'hFFFF_FFFF); rd(A_CH, v); chk("R2 chcfg", v, 32'h0000_061F);
    wr(A_IEN, 1); rd(A_IEN, v); chk("R2 ien", v, 1);
    rd(A_CLR, v); chk("R2 clr reads 0", v, 0);
    wr(A_CTRL, 32'hF5); rd(A_CTRL, v); chk("R2 ctrl", v, 32'hF5);
    chk("R2 no req", req, 0);
    wr(A_CTRL, 0); wr(A_IEN, 0);

    // table: R3 R4 R5 R6 R7
    for (int e = 0; e < 4; e++) begin
      logic [4:0] c; logic [1:0] s; logic [3:0] n; logic ie; logic [11:0] d0;
      {c, s, n, ie, d0} = VEC[e];
      wr(A_IEN, {31'd0, ie}); wr(A_CLR, 1);
      wr(A_CTRL, 1); wr(A_CH, {21'd0, s, 4'd0, c});
      wr(A_CTRL, {24'd0, n, 4'h5});
      wr(A_CTRL, {24'd0, n, 4'h7});
      for (int k = 0; k <= int'(n); k++) begin
        chk("R3 req", req, 1);
        chk("R3 chan", chan, c); chk("R3 scale", scale, s); chk("R3 mode", mode12, 1);
        rd(A_CTRL, v); chk("R3 run bit", v[1], 1);
        @(negedge clk); chk("R3 req pulse", req, 0);
        if (k < int'(n)) begin rd(A_RAW, v); chk("R7 raw early", v, 0); end
        core_done(d0 + 12'(k));
      end
      rd(A_DATA, v); chk("R4 R7 data", v, {20'd0, d0 + 12'(n)});
      rd(A_CTRL, v); chk("R4 run clear", v[1], 0);
      rd(A_RAW, v);  chk("R5 raw set", v, 1);
      rd(A_STS, v);  chk("R6 sts", v, {31'd0, ie});
      chk("R6 irq", irq, ie);
      wr(A_CLR, 0); rd(A_RAW, v); chk("R5 clear 0 no effect", v, 1);
      wr(A_CLR, 1); rd(A_RAW, v); chk("R5 cleared", v, 0);
      chk("R6 irq low", irq, 0);
    end

    // R5 set wins over same-cycle clear
    wr(A_IEN, 1); wr(A_CH, 32'd6); wr(A_CTRL, 32'h5); wr(A_CTRL, 32'h7);
    @(negedge clk);
    @(negedge clk); we = 1; addr = A_CLR; wdata = 1; done = 1; cdata = 12'h321;
    @(negedge clk); we = 0; done = 0;
    rd(A_RAW, v); chk("R5 set wins", v, 1);
    chk("R6 irq on", irq, 1);
    wr(A_CLR, 1);

    // R8 capture at start
    wr(A_CH, {21'd0, 2'd1, 4'd0, 5'd4}); wr(A_CTRL, 32'h7);
    @(negedge clk);
    wr(A_CH, {21'd0, 2'd3, 4'd0, 5'd9});
    chk("R8 chan held", chan, 4); chk("R8 scale held", scale, 1);
    rd(A_CH, v); chk("R8 reg updated", v, 32'h0000_0609);
    core_done(12'h444);
    wr(A_CTRL, 32'h7);
    chk("R8 next run chan", chan, 9); chk("R8 next run scale", scale, 3);
    @(negedge clk); core_done(12'h555);
    wr(A_CLR, 1);

    // R9 abort
    wr(A_CTRL, 32'h7); @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R9 run dropped", v[1], 0);
    chk("R9 no req", req, 0);
    core_done(12'h777);
    rd(A_DATA, v); chk("R9 data kept", v, 32'h555);
    rd(A_RAW, v);  chk("R9 raw kept", v, 0);

    // R10 disabled and busy ignores
    wr(A_CTRL, 32'h2); chk("R10 disabled run", req, 0);
    rd(A_CTRL, v); chk("R10 ctrl", v, 0);
    wr(A_CTRL, 32'h3); chk("R10 en+run same write", req, 0);
    rd(A_CTRL, v); chk("R10 run bit", v[1], 0);
    wr(A_CTRL, 32'h7); @(negedge clk);
    wr(A_CTRL, 32'h37); chk("R10 busy rerun", req, 0);
    core_done(12'h0AA);
    rd(A_RAW, v); chk("R10 not restarted", v, 1);
    rd(A_CTRL, v); chk("R10 idle after", v[1], 0);
    chk("R10 no extra req", req, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule